// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block turns one host request into the full byte-wide bus conversation with an asynchronous NAND flash device. The host presents an operation code, a page (row) index and a column offset for one clock while the block is idle. The block then holds chip enable low and issues command-latch, address-latch and data cycles with fixed strobe timing. It waits on the device ready line where the operation needs it, with a bounded timeout. It moves page bytes to or from a page-sized buffer through a simple address/data port, and raises `done` for one clock when it finishes.

Program and erase always end with a status read. The status byte is judged on its ready and fail bits, and a failure sets a sticky error flag. Error flags stay set until the host pulses `clr_err`. The buffer read port must return `buf_rdata` for `buf_addr` in the same cycle (asynchronous read).

Operation codes: 0 read page, 1 program page, 2 erase block, 3 read status, 4 read ID, 5 reset. Error bits: `err[0]` erase fail, `err[1]` program fail, `err[2]` read timeout, `err[3]` write timeout.

Top module: `nand_seq`

## Requirements
- R1: Command bytes are latched with CLE high, in this order per operation: read 0x00 … 0x30; program 0x80 … 0x10 then 0x70; erase 0x60 … 0xD0 then 0x70; status 0x70; read ID 0x90; reset 0xFF.
- R2: Read and program send five address cycles after the first command: column[7:0], then {4'b0, column[11:8]}, then the row index as three bytes with the least significant first, zero-extended to 24 bits.
- R3: Erase sends exactly three address cycles, which are the three row bytes, and no column bytes.
- R4: Read ID sends one address cycle of value 0x00, then reads five bytes into buffer addresses 0 to 4.
- R5: After program or erase, once ready is high, a 0x70 command is followed by one status read. The status byte is written to buffer address 0. If bit 6 is clear or bit 0 is set, `err[1]` is set for a program and `err[0]` is set for an erase.
- R6: A read waits for the ready line to be high after 0x30. It then reads bytes from column `col` to the end of the 2112-byte page and writes each one to buffer address `col + i`.
- R7: A program writes the buffer bytes from `col` to 2111 as data cycles. The first data strobe falls at least 6 clocks after the rising write strobe of the last address cycle. The 0x10 command follows the last data byte.
- R8: Each write or read strobe is low for exactly 2 clocks, then high for at least 1 clock. The two strobes are never low together.
- R9: If the ready line stays low for TIMEOUT_CYC clocks while the block waits, the operation ends with `done` and no status read. The error bit set is `err[2]` for a page read, and `err[3]` for program, erase or reset.
- R10: Error flags are sticky across operations and are cleared by `clr_err`.
- R11: While idle, chip enable and both strobes stay high. A request that arrives while `busy` is high is ignored. A read or program request with `col` ≥ 2112 is ignored.
- R12: A read-status operation writes the status byte to buffer address 0 and changes no error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_op | input | 3 | Operation code |
| req_page | input | ROW_BITS | Page (row) index |
| req_col | input | CW | Column offset within the page |
| clr_err | input | 1 | Clears all error flags |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| err | output | 4 | Sticky error flags |
| buf_addr | output | CW | Buffer byte address |
| buf_we | output | 1 | Buffer write enable |
| buf_wdata | output | 8 | Byte written to the buffer |
| buf_rdata | input | 8 | Byte read from the buffer at buf_addr |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_oe | output | 1 | Bus output enable |
| nand_io_out | output | 8 | Bus byte driven to the device |
| nand_io_in | input | 8 | Bus byte from the device |
| nand_rb | input | 1 | Device ready (high) / busy (low) |

## Verification
The assertions check the bus-level rules on every cycle. These are the two-clock strobe widths and the exclusion between the two strobes. They also cover the address-to-data gap of a program, the quiet bus while idle, the drop of `busy` after `done`, and the stickiness and clearing of the error flags. The scenarios are needed for the rest. Only they can show the ordered byte streams of each operation: command values, the column/row address layout, the three-cycle erase address, and the data and buffer addresses. They also show the verdict taken from the status byte, the choice of timeout flag, and that requests arriving while busy or with an out-of-range column are refused.

// File: rtl/nand_seq.sv
module nand_seq #(
  parameter int ROW_BITS    = 17,
  parameter int DATA_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  parameter int TIMEOUT_CYC = 5_000_000,
  parameter int RB_GUARD    = 3,
  parameter int ADL_GAP     = 6,
  localparam int PAGE_BYTES = DATA_BYTES + SPARE_BYTES,
  localparam int CW         = $clog2(PAGE_BYTES),
  localparam int TW         = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [2:0]          req_op,
  input  logic [ROW_BITS-1:0] req_page,
  input  logic [CW-1:0]       req_col,
  input  logic                clr_err,
  output logic                busy,
  output logic                done,
  output logic [3:0]          err,
  output logic [CW-1:0]       buf_addr,
  output logic                buf_we,
  output logic [7:0]          buf_wdata,
  input  logic [7:0]          buf_rdata,
  output logic                nand_ce_n,
  output logic                nand_cle,
  output logic                nand_ale,
  output logic                nand_we_n,
  output logic                nand_re_n,
  output logic                nand_io_oe,
  output logic [7:0]          nand_io_out,
  input  logic [7:0]          nand_io_in,
  input  logic                nand_rb
);
  localparam logic [2:0] OP_RD = 3'd0, OP_PG = 3'd1, OP_ER = 3'd2,
                         OP_ST = 3'd3, OP_ID = 3'd4, OP_RS = 3'd5;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_GAP, S_WDATA, S_CMD2,
    S_WRB, S_RDATA, S_STCMD, S_STRD, S_FIN
  } st_t;

  st_t                st, gret;
  logic [1:0]         ph;
  logic [2:0]         op, aidx;
  logic [ROW_BITS-1:0] pg;
  logic [CW-1:0]      col, cnt;
  logic [TW-1:0]      tmr;
  logic [7:0]         cmd, stat, abyte;
  logic [23:0]        row;
  logic [15:0]        colx;

  function automatic logic [7:0] first_cmd(input logic [2:0] o);
    case (o)
      OP_RD:   return 8'h00;
      OP_PG:   return 8'h80;
      OP_ER:   return 8'h60;
      OP_ST:   return 8'h70;
      OP_ID:   return 8'h90;
      default: return 8'hFF;
    endcase
  endfunction

  wire wr_cyc    = st inside {S_CMD1, S_ADDR, S_WDATA, S_CMD2, S_STCMD};
  wire rd_cyc    = st inside {S_RDATA, S_STRD};
  wire last      = (ph == 2'd2);
  wire col_bad   = (req_op == OP_RD || req_op == OP_PG) &&
                   ({1'b0, req_col} >= (CW+1)'(PAGE_BYTES));
  wire req_ok    = req_valid && (req_op <= OP_RS) && !col_bad;
  wire xfer_last = ({1'b0, col} + {1'b0, cnt}) == (CW+1)'(PAGE_BYTES - 1);
  wire rd_last   = (op == OP_ID) ? (cnt == CW'(4)) : xfer_last;
  wire addr_last = (op == OP_ID) || (aidx == 3'd4);
  wire gap_last  = (gret == S_WDATA) ? (cnt == CW'(ADL_GAP - 1)) : 1'b1;
  wire stat_bad  = !stat[6] || stat[0];

  assign row  = 24'(pg);
  assign colx = 16'(col);

  always_comb begin
    case (aidx)
      3'd0:    abyte = colx[7:0];
      3'd1:    abyte = {4'b0, colx[11:8]};
      3'd2:    abyte = row[7:0];
      3'd3:    abyte = row[15:8];
      default: abyte = row[23:16];
    endcase
  end

  assign busy        = (st != S_IDLE);
  assign done        = (st == S_FIN);
  assign nand_ce_n   = (st == S_IDLE);
  assign nand_cle    = st inside {S_CMD1, S_CMD2, S_STCMD};
  assign nand_ale    = (st == S_ADDR);
  assign nand_we_n   = !(wr_cyc && !last);
  assign nand_re_n   = !(rd_cyc && !last);
  assign nand_io_oe  = wr_cyc;
  assign nand_io_out = (st == S_ADDR) ? abyte : (st == S_WDATA) ? buf_rdata : cmd;
  assign buf_we      = rd_cyc && (ph == 2'd1);
  assign buf_wdata   = nand_io_in;
  assign buf_addr    = (st == S_STRD) ? '0 : col + cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; gret <= S_IDLE; ph <= '0; op <= '0; aidx <= '0;
      pg <= '0; col <= '0; cnt <= '0; tmr <= '0; cmd <= '0; stat <= '0; err <= '0;
    end else begin
      if (clr_err) err <= '0;
      if (wr_cyc || rd_cyc) ph <= last ? 2'd0 : ph + 2'd1;
      case (st)
        S_IDLE: if (req_ok) begin
          op  <= req_op;
          pg  <= req_page;
          col <= (req_op == OP_ID) ? '0 : req_col;
          cmd <= first_cmd(req_op);
          cnt <= '0; aidx <= '0; ph <= '0;
          st  <= S_CMD1;
        end
        S_CMD1: if (last) begin
          cnt <= '0; tmr <= '0;
          case (op)
            OP_ER:   begin st <= S_ADDR; aidx <= 3'd2; end
            OP_ST:   begin st <= S_GAP;  gret <= S_STRD; end
            OP_RS:   st <= S_WRB;
            default: begin st <= S_ADDR; aidx <= 3'd0; end
          endcase
        end
        S_ADDR: if (last) begin
          aidx <= aidx + 3'd1;
          cnt  <= '0;
          if (addr_last) begin
            case (op)
              OP_RD:   begin st <= S_CMD2; cmd <= 8'h30; end
              OP_ER:   begin st <= S_CMD2; cmd <= 8'hD0; end
              OP_PG:   begin st <= S_GAP;  gret <= S_WDATA; end
              default: begin st <= S_GAP;  gret <= S_RDATA; end
            endcase
          end
        end
        S_GAP: begin
          cnt <= cnt + 1'b1;
          if (gap_last) begin st <= gret; cnt <= '0; ph <= '0; end
        end
        S_WDATA: if (last) begin
          cnt <= cnt + 1'b1;
          if (xfer_last) begin st <= S_CMD2; cmd <= 8'h10; cnt <= '0; end
        end
        S_CMD2: if (last) begin st <= S_WRB; cnt <= '0; tmr <= '0; end
        S_WRB: begin
          tmr <= tmr + 1'b1;
          if (cnt < CW'(RB_GUARD)) cnt <= cnt + 1'b1;
          else if (nand_rb) begin
            cnt <= '0; ph <= '0;
            case (op)
              OP_RD:   st <= S_RDATA;
              OP_RS:   st <= S_FIN;
              default: begin st <= S_STCMD; cmd <= 8'h70; end
            endcase
          end
          if (!(cnt >= CW'(RB_GUARD) && nand_rb) && tmr == TW'(TIMEOUT_CYC - 1)) begin
            st <= S_FIN;
            if (op == OP_RD) err[2] <= 1'b1; else err[3] <= 1'b1;
          end
        end
        S_STCMD: if (last) begin st <= S_GAP; gret <= S_STRD; cnt <= '0; end
        S_RDATA: if (last) begin
          cnt <= cnt + 1'b1;
          if (rd_last) st <= S_FIN;
        end
        S_STRD: begin
          if (ph == 2'd1) stat <= nand_io_in;
          if (last) begin
            st <= S_FIN;
            if (op == OP_PG && stat_bad) err[1] <= 1'b1;
            if (op == OP_ER && stat_bad) err[0] <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module nand_seq_chk #(
  parameter int ADL_GAP = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic [3:0] err,
  input logic       clr_err,
  input logic       nand_ce_n,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic       nand_io_oe
);
  logic       prev_we, armed;
  logic [7:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_we <= 1'b1; armed <= 1'b0; since <= '0;
    end else begin
      prev_we <= nand_we_n;
      if (!prev_we && nand_we_n && nand_ale) begin
        armed <= 1'b1; since <= '0;
      end else begin
        if (since != 8'hFF) since <= since + 8'd1;
        if (prev_we && !nand_we_n && !nand_ale) armed <= 1'b0;
      end
    end
  end

  assert_adl_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && prev_we && !nand_we_n && !nand_cle && !nand_ale) |-> (since >= 8'(ADL_GAP)));

  assert_we_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_we_n) |=> !nand_we_n ##1 nand_we_n);

  assert_re_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_re_n) |=> !nand_re_n ##1 nand_re_n);

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  assert_idle_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (nand_ce_n && nand_we_n && nand_re_n && !nand_io_oe));

  assert_done_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_err && !busy) |=> (err == 4'd0));

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_err |=> ((err & $past(err)) == $past(err)));
endmodule

bind nand_seq nand_seq_chk #(.ADL_GAP(ADL_GAP)) u_chk (.*);

// File: tb/tb_nand_seq.sv
module tb_nand_seq;
  localparam int ROWB = 17;
  localparam int PAGE = 2112;
  localparam int CWB  = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic            req_valid = 1'b0, clr_err = 1'b0;
  logic [2:0]      req_op = '0;
  logic [ROWB-1:0] req_page = '0;
  logic [CWB-1:0]  req_col = '0;
  logic busy, done, buf_we, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [3:0]      err;
  logic [CWB-1:0]  buf_addr;
  logic [7:0]      buf_wdata, buf_rdata, nand_io_out, nand_io_in;
  logic            nand_rb = 1'b1;

  nand_seq #(.ROW_BITS(ROWB), .TIMEOUT_CYC(400)) dut (.*);

  logic [7:0]  bmem [PAGE];
  logic [7:0]  last_cmd = 8'hFF, rd_idx = '0, status_val = 8'h40;
  int          rb_left = 0, rb_low = 12, cyc = 0, adl_mark = 0;
  bit          hang = 0, adl_arm = 0;
  logic        p_we = 1'b1, p_re = 1'b1;
  int          we_lo = 0, re_lo = 0;
  int          n_tests = 0, n_fail = 0;
  string       cur_req = "R1";
  logic [9:0]  exp_bus [$];
  logic [19:0] exp_buf [$];

  assign buf_rdata  = bmem[buf_addr];
  assign nand_io_in = (last_cmd == 8'h70) ? status_val : 8'h5A + rd_idx;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rb_left > 0) rb_left--;
    if (!nand_we_n) we_lo++;
    if (!nand_re_n) re_lo++;
    if (p_we && !nand_we_n && !nand_ale) begin
      if (adl_arm && !nand_cle) chk(cyc - adl_mark >= 6, "R7 addr-to-data gap", cyc - adl_mark, 6);
      adl_arm = 0;
    end
    if (!p_we && nand_we_n) begin
      chk(we_lo == 2, "R8 write strobe width", we_lo, 2);
      we_lo = 0;
      if (exp_bus.size() == 0) chk(0, {cur_req, " unexpected bus cycle"}, {nand_cle, nand_ale, nand_io_out}, 0);
      else begin
        logic [9:0] e;
        e = exp_bus.pop_front();
        chk({nand_cle, nand_ale, nand_io_out} == e, {cur_req, " bus cycle"}, {nand_cle, nand_ale, nand_io_out}, e);
      end
      if (nand_ale) begin adl_arm = 1; adl_mark = cyc; end
      if (nand_cle) begin
        last_cmd = nand_io_out;
        rd_idx = '0;
        if (nand_io_out inside {8'h30, 8'h10, 8'hD0, 8'hFF}) rb_left = hang ? 1000000 : rb_low;
      end
    end
    if (!p_re && nand_re_n) begin
      chk(re_lo == 2, "R8 read strobe width", re_lo, 2);
      re_lo = 0;
      rd_idx = rd_idx + 8'd1;
    end
    chk(nand_we_n || nand_re_n, "R8 strobe overlap", 0, 1);
    if (buf_we) begin
      if (exp_buf.size() == 0) chk(0, {cur_req, " unexpected buffer write"}, {buf_addr, buf_wdata}, 0);
      else begin
        logic [19:0] e;
        e = exp_buf.pop_front();
        chk({buf_addr, buf_wdata} == e, {cur_req, " buffer write"}, {buf_addr, buf_wdata}, e);
      end
      bmem[buf_addr] = buf_wdata;
    end
    nand_rb = (rb_left == 0);
    p_we = nand_we_n;
    p_re = nand_re_n;
  end

  task automatic push_cmd(input logic [7:0] b);  exp_bus.push_back({2'b10, b}); endtask
  task automatic push_addr(input logic [7:0] b); exp_bus.push_back({2'b01, b}); endtask

  task automatic do_op(input logic [2:0] op, input logic [ROWB-1:0] pg, input logic [CWB-1:0] col,
                       input string tag, input logic [3:0] exp_err, input bit poke);
    logic [23:0] r;
    bit got;
    r = 24'(pg);
    cur_req = tag;
    case (op)
      3'd0: begin
        push_cmd(8'h00);
        push_addr(col[7:0]); push_addr({4'b0, col[11:8]});
        push_addr(r[7:0]); push_addr(r[15:8]); push_addr(r[23:16]);
        push_cmd(8'h30);
        if (!hang) for (int i = int'(col); i < PAGE; i++)
          exp_buf.push_back({CWB'(i), 8'(8'h5A + 8'(i - int'(col)))});
      end
      3'd1: begin
        push_cmd(8'h80);
        push_addr(col[7:0]); push_addr({4'b0, col[11:8]});
        push_addr(r[7:0]); push_addr(r[15:8]); push_addr(r[23:16]);
        for (int i = int'(col); i < PAGE; i++) exp_bus.push_back({2'b00, bmem[i]});
        push_cmd(8'h10);
        if (!hang) begin push_cmd(8'h70); exp_buf.push_back({CWB'(0), status_val}); end
      end
      3'd2: begin
        push_cmd(8'h60);
        push_addr(r[7:0]); push_addr(r[15:8]); push_addr(r[23:16]);
        push_cmd(8'hD0);
        if (!hang) begin push_cmd(8'h70); exp_buf.push_back({CWB'(0), status_val}); end
      end
      3'd3: begin push_cmd(8'h70); exp_buf.push_back({CWB'(0), status_val}); end
      3'd4: begin
        push_cmd(8'h90); push_addr(8'h00);
        for (int i = 0; i < 5; i++) exp_buf.push_back({CWB'(i), 8'(8'h5A + i)});
      end
      default: push_cmd(8'hFF);
    endcase
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_page = pg; req_col = col;
    @(negedge clk);
    req_valid = 1'b0;
    got = 0;
    for (int k = 0; k < 20000; k++) begin
      if (poke && k == 10) begin req_valid = 1'b1; req_op = 3'd5; end
      if (poke && k == 11) req_valid = 1'b0;
      if (done) begin got = 1; break; end
      @(negedge clk);
    end
    chk(got, {tag, " done seen (watchdog)"}, got, 1);
    chk(err == exp_err, {tag, " error flags"}, err, exp_err);
    @(negedge clk);
    chk(!busy, {tag, " busy low after done"}, busy, 0);
    chk(exp_bus.size() == 0, {tag, " all bus cycles seen"}, exp_bus.size(), 0);
    chk(exp_buf.size() == 0, {tag, " all buffer writes seen"}, exp_buf.size(), 0);
    exp_bus.delete(); exp_buf.delete();
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_err = 1'b1;
    @(negedge clk); clr_err = 1'b0;
    @(negedge clk);
    chk(err == 4'd0, "R10 clear flags", err, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < PAGE; i++) bmem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && err == 0, "R11 reset idle state", {busy, done, err}, 0);
    chk(nand_ce_n && nand_we_n && nand_re_n, "R11 reset bus idle",
        {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);

    do_op(3'd0, 17'h1A5C3, 12'd2100, "R2 R6 read tail of page", 4'd0, 0);
    do_op(3'd0, 17'h00005, 12'd0, "R6 read full page", 4'd0, 0);
    do_op(3'd1, 17'h0F0F1, 12'd2104, "R7 R5 program pass", 4'd0, 0);
    do_op(3'd2, 17'h1ABCD, 12'd0, "R3 erase row cycles", 4'd0, 0);
    do_op(3'd4, 17'h1FFFF, 12'd77, "R4 read id", 4'd0, 0);
    status_val = 8'hE0;
    do_op(3'd3, 17'h0, 12'd0, "R12 status op", 4'd0, 0);
    do_op(3'd5, 17'h0, 12'd0, "R1 reset op", 4'd0, 0);

    status_val = 8'h41;
    do_op(3'd1, 17'h00321, 12'd2110, "R5 program fail bit0", 4'd2, 0);
    status_val = 8'h40;
    do_op(3'd3, 17'h0, 12'd0, "R10 flag sticky across ops", 4'd2, 0);
    pulse_clr();

    status_val = 8'h00;
    do_op(3'd2, 17'h00077, 12'd0, "R5 erase not ready", 4'd1, 0);
    status_val = 8'h40;
    pulse_clr();

    hang = 1;
    do_op(3'd0, 17'h00099, 12'd2108, "R9 read timeout", 4'd4, 0);
    pulse_clr();
    do_op(3'd2, 17'h000AA, 12'd0, "R9 erase timeout", 4'd8, 0);
    hang = 0; rb_left = 0;
    @(negedge clk);
    pulse_clr();

    do_op(3'd4, 17'h0, 12'd0, "R11 request while busy ignored", 4'd0, 1);

    cur_req = "R11 column out of range";
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd0; req_col = 12'd2112;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk(!busy && nand_ce_n, "R11 column out of range ignored", busy, 0);
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd1; req_col = 12'd4095;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk(!busy && nand_ce_n, "R11 program column out of range ignored", busy, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule